// File: doc/BRIEF.md
# Interrupt Redirection and Message Controller

This block converts a group of level-sensitive interrupt lines into memory-write interrupt messages. Each line owns two words in a 32-word redirection table: a control word that holds the vector and a mask bit, and a destination word that holds a scrambled form of the target address. Software reaches the table indirectly. It writes a table index to a select register and then reads or writes the chosen word through a data window register on a simple register bus.

When an unmasked line is high and its pending bit is clear, the block sets the pending bit and queues a message. The message is a 32-bit write of the line's vector to the decoded destination. A pending bit is cleared when its line drops, or when an end-of-interrupt write names its vector. A line that is still high after an end-of-interrupt is therefore delivered again.

Messages leave through an address/data request with a valid/ready handshake, backed by a 2-deep queue. Lines that fire while the queue is full wait in per-line request latches and are served lowest index first.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset, msg_valid is low. Table word 0x10+2*i reads 0x0001A000 + (i+2): mask bit 16, level bit 15, polarity bit 13 and vector i+2. Word 0x11+2*i reads 0xA0FF0000, which is the scrambled form of the default processor address 0xFFFA0000. Every other writable word reads 0.
- R2: Register offsets are select = 0x800, window = 0x810 and end-of-interrupt = 0x840. The select register reads back what was written. The window reads and writes table word [select]. Read data and bus_rvalid appear one cycle after the read request. Reads of any other offset return 0.
- R3: A window read with select = 1 returns the version word 0x00200001, which carries the table size in bits 31:16.
- R4: Window writes with select of 32 or more change no table word, and window reads with such a select return 0.
- R5: A line that is high, with mask bit 16 of its control word clear and its pending bit clear, produces exactly one message. On an idle queue, msg_valid rises at the second clock edge after the line is first sampled high. Holding the line high produces no further message. Control bits 15, 13 and 8 are stored but do not change triggering.
- R6: A masked line produces no message while it is masked. Clearing the mask while the line is still high produces one message.
- R7: The message address is {4'hF, dest[23:16], dest[31:24], 12'h000}, where dest is the line's destination word. Bits 15:0 of dest are ignored.
- R8: The message data holds the vector (control word bits 5:0) in bits 29:24, with all other bits zero. This is the big-endian byte order of a 32-bit write on a lane-0-low bus.
- R9: Dropping the line clears its pending bit, so raising the line again produces a new message.
- R10: An end-of-interrupt write whose full 32-bit value equals a line's vector clears that line's pending bit, for every matching line. Matching lines that are still high are delivered again. Lines that do not match, and values with bits above bit 5 set, have no effect.
- R11: When an end-of-interrupt write and a new firing of the same line fall in the same cycle, the firing wins. Exactly one message results, and the line stays pending.
- R12: msg_addr and msg_data hold steady while msg_valid is high and msg_ready is low. Lines that fire together are all delivered, in ascending line order, none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_in | input | NUM_IN | Level interrupt lines, active high |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Two functions can fall in the same cycle: an end-of-interrupt that names a line's vector, and a new firing of that same line. The bench provokes this by raising the line and driving the matching end-of-interrupt write on the same clock edge. It judges the result by requiring exactly one message and then silence, because a clear that won would allow a second delivery on the next cycle. A second collision happens when all lines fire together against a held-off queue. The bench checks that the outputs stay stable and that all eight messages drain in line order.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int unsigned MASK_BIT   = 16;
  localparam int unsigned LEVEL_BIT  = 15;
  localparam int unsigned POLLO_BIT  = 13;
  localparam int unsigned LOWPRI_BIT = 8;
  localparam int unsigned VEC_W      = 6;
  localparam int unsigned VEC_OFS    = 2;
  localparam int unsigned ENTRY_BASE = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_t;

  function automatic logic [31:0] dest_decode(input logic [31:0] s);
    return {4'hF, s[23:16], s[31:24], 12'h000};
  endfunction

  function automatic logic [31:0] dest_encode(input logic [31:0] a);
    return {a[19:12], a[27:20], 16'h0000};
  endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_msg_pkg::*;
#(
  parameter int unsigned NUM_IN    = 8,
  parameter int unsigned TBL_WORDS = 32,
  parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000,
  localparam int unsigned IDX_W    = $clog2(TBL_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [31:0]                   wr_data,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [31:0]                   rd_data,
  output logic [NUM_IN-1:0][31:0]       low_words,
  output logic [NUM_IN-1:0][31:0]       dst_words
);
  function automatic logic [31:0] init_word(input int k);
    logic [31:0] ctl;
    ctl = (32'd1 << MASK_BIT) | (32'd1 << LEVEL_BIT) | (32'd1 << POLLO_BIT);
    if (k >= int'(ENTRY_BASE) && k < int'(ENTRY_BASE + 2 * NUM_IN)) begin
      if (((k - int'(ENTRY_BASE)) % 2) == 0)
        return ctl | 32'((k - int'(ENTRY_BASE)) / 2 + int'(VEC_OFS));
      else
        return dest_encode(CPU_ADDR);
    end
    return 32'h0;
  endfunction

  logic [31:0] tbl [TBL_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(TBL_WORDS); k++) tbl[k] <= init_word(k);
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_data;
    end
  end

  assign rd_data = tbl[rd_idx];

  for (genvar i = 0; i < int'(NUM_IN); i++) begin : g_taps
    assign low_words[i] = tbl[ENTRY_BASE + 2 * i];
    assign dst_words[i] = tbl[ENTRY_BASE + 2 * i + 1];
  end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned VEC_W  = 6,
  localparam int unsigned IW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_IN-1:0]            irq_in,
  input  logic [NUM_IN-1:0]            masked,
  input  logic [NUM_IN-1:0][VEC_W-1:0] vec,
  input  logic                         eoi_stb,
  input  logic [31:0]                  eoi_val,
  input  logic                         room,
  output logic                         grant_vld,
  output logic [IW-1:0]                grant_idx
);
  logic [NUM_IN-1:0] pend_q, req_q;
  logic [NUM_IN-1:0] active, fire, eoi_hit, grant_oh;

  for (genvar i = 0; i < int'(NUM_IN); i++) begin : g_line
    assign active[i]  = irq_in[i] & ~masked[i];
    assign fire[i]    = active[i] & ~pend_q[i];
    assign eoi_hit[i] = eoi_stb && (eoi_val == 32'(vec[i]));
  end

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    for (int i = int'(NUM_IN) - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        grant_vld = room;
        grant_idx = IW'(i);
      end
    end
  end

  assign grant_oh = grant_vld ? (NUM_IN'(1) << grant_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      pend_q <= fire | (pend_q & irq_in & ~eoi_hit);
      req_q  <= (req_q & ~grant_oh) | fire;
    end
  end
endmodule

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 64,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         room
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout      = mem[rptr];
  assign not_empty = (cnt != '0);
  assign room      = (cnt < CW'(DEPTH));
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int unsigned NUM_IN    = 8,
  parameter int unsigned TBL_WORDS = 32,
  parameter int unsigned REG_AW    = 12,
  parameter int unsigned QDEPTH    = 2,
  parameter logic [31:0] CPU_ADDR  = 32'hFFFA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int unsigned IDX_W = $clog2(TBL_WORDS);
  localparam int unsigned IW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam logic [REG_AW-1:0] OFS_SEL = REG_AW'(12'h800);
  localparam logic [REG_AW-1:0] OFS_WIN = REG_AW'(12'h810);
  localparam logic [REG_AW-1:0] OFS_EOI = REG_AW'(12'h840);
  localparam logic [31:0] VERSION_WORD = (32'(TBL_WORDS) << 16) | 32'd1;

  logic [31:0] sel_q;
  logic        is_sel, is_win, is_eoi, sel_ok, rd_stb, tbl_we;
  logic [31:0] tbl_rd, rd_mux;

  logic [NUM_IN-1:0][31:0]       low_words, dst_words;
  logic [NUM_IN-1:0]             masked;
  logic [NUM_IN-1:0][VEC_W-1:0]  vec;
  logic                          grant_vld, room;
  logic [IW-1:0]                 grant_idx;
  msg_t                          push_pkt, head_pkt;

  assign is_sel = (bus_addr == OFS_SEL);
  assign is_win = (bus_addr == OFS_WIN);
  assign is_eoi = (bus_addr == OFS_EOI);
  assign sel_ok = (sel_q < 32'(TBL_WORDS));
  assign rd_stb = bus_en & ~bus_we;
  assign tbl_we = bus_en & bus_we & is_win & sel_ok;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (bus_en && bus_we && is_sel) sel_q <= bus_wdata;
  end

  irq_redir_table #(
    .NUM_IN(NUM_IN), .TBL_WORDS(TBL_WORDS), .CPU_ADDR(CPU_ADDR)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_idx(sel_q[IDX_W-1:0]), .wr_data(bus_wdata),
    .rd_idx(sel_q[IDX_W-1:0]), .rd_data(tbl_rd),
    .low_words(low_words), .dst_words(dst_words)
  );

  always_comb begin
    rd_mux = 32'h0;
    if (is_sel) rd_mux = sel_q;
    else if (is_win) begin
      if (sel_q == 32'd1) rd_mux = VERSION_WORD;
      else if (sel_ok)    rd_mux = tbl_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_stb;
      if (rd_stb) bus_rdata <= rd_mux;
    end
  end

  for (genvar i = 0; i < int'(NUM_IN); i++) begin : g_fields
    assign masked[i] = low_words[i][MASK_BIT];
    assign vec[i]    = low_words[i][VEC_W-1:0];
  end

  irq_pend_track #(.NUM_IN(NUM_IN), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst(rst),
    .irq_in(irq_in), .masked(masked), .vec(vec),
    .eoi_stb(bus_en & bus_we & is_eoi), .eoi_val(bus_wdata),
    .room(room), .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  assign push_pkt.addr = dest_decode(dst_words[grant_idx]);
  assign push_pkt.data = 32'(vec[grant_idx]) << 24;

  irq_msg_fifo #(.DEPTH(QDEPTH), .W($bits(msg_t))) u_q (
    .clk(clk), .rst(rst),
    .push(grant_vld), .din(push_pkt),
    .pop(msg_valid & msg_ready), .dout(head_pkt),
    .not_empty(msg_valid), .room(room)
  );

  assign msg_addr = head_pkt.addr;
  assign msg_data = head_pkt.data;
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int unsigned REG_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic              bus_rvalid,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [31:0]       msg_addr,
  input logic [31:0]       msg_data
);
  // R12: a stalled request keeps its contents
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R7: decoded addresses carry the forced top nibble and a page-aligned offset
  a_r7_addr_form: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:28] == 4'hF) && (msg_addr[11:0] == 12'h000));

  // R8: only the vector field may be nonzero
  a_r8_data_form: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:30] == 2'b00) && (msg_data[23:0] == 24'h0));

  // R2: every read is answered on the next cycle
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_en && !bus_we |=> bus_rvalid);

  // R2: no answer without a read
  a_r2_rvalid_only: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> !bus_rvalid);
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_rvalid(bus_rvalid), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [5:0]  vec_of [N];
  logic [31:0] dst_of [N];

  always #2 clk = ~clk;

  irq_msg_ctrl dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_in(irq_in), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] s);
    return 32'hF000_0000 | (((s >> 16) & 32'hFF) << 20) | (((s >> 24) & 32'hFF) << 12);
  endfunction

  function automatic logic [31:0] exp_data(input logic [5:0] v);
    return 32'(v) * 32'h0100_0000;
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic win_wr(input int idx, input logic [31:0] d);
    bus_wr(12'h800, 32'(idx));
    bus_wr(12'h810, d);
  endtask

  task automatic win_rd(input int idx, output logic [31:0] d);
    logic v;
    bus_wr(12'h800, 32'(idx));
    bus_rd(12'h810, d, v);
  endtask

  task automatic get_msg(output logic [31:0] a, output logic [31:0] d, output bit got);
    got = 1'b0; a = '0; d = '0;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (msg_valid) begin
        a = msg_addr; d = msg_data; got = 1'b1;
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        break;
      end
    end
  endtask

  task automatic expect_msg(input string tag, input int line);
    logic [31:0] a, d; bit got;
    get_msg(a, d, got);
    chk({tag, " got"}, 32'(got), 32'd1);
    chk({tag, " addr"}, a, exp_addr(dst_of[line]));
    chk({tag, " data"}, d, exp_data(vec_of[line]));
  endtask

  task automatic expect_quiet(input string tag, input int cyc);
    int seen = 0;
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      if (msg_valid) seen++;
    end
    chk({tag, " quiet"}, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 msg_valid idle", 32'(msg_valid), 32'd0);
    for (int i = 0; i < N; i++) begin
      win_rd(16 + 2 * i, d);
      chk("R1 control word", d, 32'h0001_A000 + 32'(i + 2));
      win_rd(17 + 2 * i, d);
      chk("R1 destination word", d, 32'hA0FF_0000);
    end
    win_rd(0, d);  chk("R1 spare word 0", d, 32'h0);
    win_rd(9, d);  chk("R1 spare word 9", d, 32'h0);

    // R2 select readback, window storage, read timing, unmapped offset
    bus_wr(12'h800, 32'h0000_0005);
    bus_rd(12'h800, d, v);
    chk("R2 select readback", d, 32'h5);
    chk("R2 rvalid one cycle later", 32'(v), 32'd1);
    win_wr(3, 32'hC0DE_1234);
    win_rd(3, d);
    chk("R2 window round trip", d, 32'hC0DE_1234);
    bus_rd(12'h100, d, v);
    chk("R2 unmapped reads zero", d, 32'h0);

    // R3 version word
    win_rd(1, d);
    chk("R3 version word", d, 32'h0020_0001);

    // R4 out-of-range select
    win_wr(40, 32'hDEAD_BEEF);
    win_rd(40, d);
    chk("R4 out-of-range read", d, 32'h0);
    win_rd(8, d);
    chk("R4 no aliasing write", d, 32'h0);

    // Program every line; odd lines carry the stored-only control bits
    for (int i = 0; i < N; i++) begin
      vec_of[i] = 6'((i * 7 + 33) & 63);
      dst_of[i] = {8'(i * 16 + 1), 8'(8'h80 + i * 3), 16'hBEEF};
      win_wr(17 + 2 * i, dst_of[i]);
      win_wr(16 + 2 * i, ((i % 2) == 1 ? 32'h0000_A100 : 32'h0) | 32'(vec_of[i]));
    end

    // R5 R7 R8 R9 sweep over every line
    for (int i = 0; i < N; i++) begin
      logic [31:0] a0, d0;
      @(negedge clk);
      irq_in[i] = 1'b1;
      @(negedge clk);
      chk("R5 no message after one edge", 32'(msg_valid), 32'd0);
      @(negedge clk);
      chk("R5 message after two edges", 32'(msg_valid), 32'd1);
      a0 = msg_addr; d0 = msg_data;
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      chk("R7 decoded address", a0, exp_addr(dst_of[i]));
      chk("R8 vector placement", d0, exp_data(vec_of[i]));
      expect_quiet("R5 held line fires once", 6);
      irq_in[i] = 1'b0;
      @(negedge clk);
      irq_in[i] = 1'b1;
      expect_msg("R9 reassert fires again", i);
      irq_in[i] = 1'b0;
      expect_quiet("R9 after drop", 3);
    end

    // R6 masked line, then unmask while high
    win_wr(20, 32'h0001_0000 | 32'(vec_of[2]));
    @(negedge clk); irq_in[2] = 1'b1;
    expect_quiet("R6 masked line", 8);
    win_wr(20, 32'(vec_of[2]));
    expect_msg("R6 unmask while high", 2);
    irq_in[2] = 1'b0;
    expect_quiet("R6 after drop", 3);

    // R10 end-of-interrupt by vector match
    vec_of[4] = 6'h11; vec_of[5] = 6'h11; vec_of[6] = 6'h12;
    win_wr(24, 32'h11); win_wr(26, 32'h11); win_wr(28, 32'h12);
    @(negedge clk); irq_in[6:4] = 3'b111;
    expect_msg("R10 first line4", 4);
    expect_msg("R10 first line5", 5);
    expect_msg("R10 first line6", 6);
    expect_quiet("R10 settled", 4);
    bus_wr(12'h840, 32'h11);
    expect_msg("R10 redeliver line4", 4);
    expect_msg("R10 redeliver line5", 5);
    expect_quiet("R10 non-matching line6", 6);
    bus_wr(12'h840, 32'h111);
    expect_quiet("R10 upper bits no match", 6);
    bus_wr(12'h840, 32'h12);
    expect_msg("R10 redeliver line6", 6);
    expect_quiet("R10 done", 3);
    irq_in[6:4] = 3'b000;
    @(negedge clk);

    // R11 end-of-interrupt and new firing in the same cycle
    vec_of[3] = 6'd9;
    win_wr(22, 32'd9);
    @(negedge clk);
    irq_in[3] = 1'b1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h840; bus_wdata = 32'd9;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    expect_msg("R11 firing wins", 3);
    expect_quiet("R11 single message", 8);
    irq_in[3] = 1'b0;
    @(negedge clk);

    // R12 back-pressure with all lines firing together
    @(negedge clk); irq_in = '1;
    repeat (8) @(negedge clk);
    begin
      logic [31:0] a0, d0;
      chk("R12 valid under stall", 32'(msg_valid), 32'd1);
      a0 = msg_addr; d0 = msg_data;
      repeat (5) @(negedge clk);
      chk("R12 addr stable", msg_addr, a0);
      chk("R12 data stable", msg_data, d0);
    end
    for (int i = 0; i < N; i++) expect_msg("R12 ascending drain", i);
    expect_quiet("R12 none extra", 6);
    irq_in = '0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule